// File: doc/BRIEF.md
# Seven-to-one serial pixel receiver with word alignment

This block takes one sample per bit period from a serial clock lane and from three or four data lanes of a 7:1 flat-panel link. It finds where each seven-slot word starts by searching for the clock lane's fixed slot pattern. Once that pattern has repeated cleanly for enough words, it declares lock and turns each aligned word into one pixel: 8-bit red, green and blue plus horizontal sync, vertical sync and data enable.

Three packing schemes are supported. One is a narrow scheme that carries 6 bits per colour on three lanes. The other two are wide schemes that add a fourth lane and differ in which colour bits that lane carries. A mirror input handles transmitters that send each word's slots in reverse order. The receiver works entirely in the bit-rate clock domain. Bit-phase recovery and lane skew correction are left to the logic in front of it.

Top module: `lvds_rx_align`

## Requirements
- R1: A synchronous reset clears the lock flag, the pixel strobe, all three colour outputs and the three control outputs to zero.
- R2: While unlocked, a word boundary whose clock-lane slots do not match moves the next boundary evaluation to eight bit periods later instead of seven, so the receiver locks from any of the seven starting offsets.
- R3: The expected clock-lane value for slots 0 to 6 is 1,1,0,0,0,1,1, and without mirroring slot 0 is the first bit received. Lock rises at the boundary of the fourth consecutive matching word.
- R4: While locked, one mismatched word keeps lock, and a match clears the miss count. A second consecutive mismatch drops lock at that word's boundary, and the fourth matching word after that locks again.
- R5: `pix_valid_o` is a single-cycle pulse, raised only while locked, on the clock edge that samples a word's seventh bit. The pulse includes the word that achieves lock, and the pixel outputs update on that same edge.
- R6: In map mode 0 only lanes 0 to 2 are used. Lane 0 carries green bit 0 in slot 0 and red bits 5 down to 0 in slots 1 to 6. Lane 1 carries blue bits 1 and 0 in slots 0 and 1, then green bits 5 down to 1. Lane 2 carries the control bits in slots 0 to 2, then blue bits 5 down to 2. Each 6-bit colour c is output as {c, c[5:4]}, and lane 3 is ignored.
- R7: In map mode 2 the 6-bit fields of R6 are colour bits 5:0. Lane 3 slots 1 to 6 carry blue 7, blue 6, green 7, green 6, red 7 and red 6.
- R8: In map mode 1 the 6-bit fields of R6 are colour bits 7:2. Lane 3 slots 1 to 6 carry blue 1, blue 0, green 1, green 0, red 1 and red 0.
- R9: Lane 2 slot 0 is data enable, slot 1 is vertical sync and slot 2 is horizontal sync, in every map mode.
- R10: With `mirror_i` high, each lane's slots arrive in the order 6 down to 0, and decoding is otherwise unchanged.
- R11: Map mode 3 decodes exactly as map mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one lane sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mirror_i | input | 1 | Slots arrive 6 down to 0 when high |
| map_mode_i | input | 2 | 0 narrow, 1 wide with low bits on lane 3, 2 wide with high bits on lane 3, 3 as 0 |
| clk_lane_i | input | 1 | Clock-lane sample |
| data_lane_i | input | DATA_LANES | Data-lane samples, bit n is lane n |
| red_o | output | 8 | Decoded red |
| green_o | output | 8 | Decoded green |
| blue_o | output | 8 | Decoded blue |
| hsync_o | output | 1 | Decoded horizontal sync |
| vsync_o | output | 1 | Decoded vertical sync |
| de_o | output | 1 | Decoded data enable |
| pix_valid_o | output | 1 | One-cycle strobe per word decoded while locked |
| locked_o | output | 1 | Word alignment locked |

## Verification
Every result registers on the edge that samples a word's seventh bit. That edge updates the pixel fields, `pix_valid_o` and any change of `locked_o`. The bench therefore drives one slot per falling edge and samples 1 ns after the rising edge that takes the last slot. No output is read between those points, apart from a mid-word check that the strobe has gone low again. With no leading offset, lock is due exactly after the fourth word from reset, and the bench checks that edge. For the other six offsets it allows up to sixteen words, which covers seven eight-cycle slips plus four matches.

// File: rtl/lvds_rx_pkg.sv
package lvds_rx_pkg;

   localparam int WORD_SLOTS = 7;

   // bit k is the clock-lane value expected in slot k
   localparam logic [WORD_SLOTS-1:0] CLK_SLOT_PATTERN = 7'b1100011;

   typedef enum logic [1:0] {
      MAP_NARROW     = 2'd0,
      MAP_WIDE_LOLN3 = 2'd1,
      MAP_WIDE_HILN3 = 2'd2,
      MAP_NARROW_ALT = 2'd3
   } map_mode_e;

endpackage

// File: rtl/lvds_slot_deser.sv
module lvds_slot_deser
   import lvds_rx_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  bit_i,
   input  logic                  mirror_i,
   output logic [WORD_SLOTS-1:0] slots_o
);

   logic [WORD_SLOTS-2:0] hist_q;
   logic [WORD_SLOTS-1:0] window;

   always_ff @(posedge clk) begin
      if (rst) hist_q <= '0;
      else     hist_q <= {hist_q[WORD_SLOTS-3:0], bit_i};
   end

   // window[WORD_SLOTS-1] is the oldest of the last seven samples
   assign window = {hist_q, bit_i};

   for (genvar k = 0; k < WORD_SLOTS; k++) begin : g_slot
      assign slots_o[k] = mirror_i ? window[k] : window[WORD_SLOTS-1-k];
   end

endmodule

// File: rtl/lvds_word_align.sv
module lvds_word_align
   import lvds_rx_pkg::*;
#(
   parameter int LOCK_WORDS = 4,
   parameter int DROP_WORDS = 2
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic [WORD_SLOTS-1:0] clk_slots_i,
   output logic                  boundary_o,
   output logic                  lock_next_o,
   output logic                  locked_o
);

   localparam int CNT_W  = $clog2(WORD_SLOTS + 1);
   localparam int GOOD_W = $clog2(LOCK_WORDS + 1);
   localparam int BAD_W  = $clog2(DROP_WORDS + 1);

   if (LOCK_WORDS < 1) begin : g_bad_lock
      $error("LOCK_WORDS must be at least 1");
   end
   if (DROP_WORDS < 1) begin : g_bad_drop
      $error("DROP_WORDS must be at least 1");
   end

   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic [GOOD_W-1:0] good_q, good_n;
   logic [BAD_W-1:0]  bad_q, bad_n;
   logic              locked_q, locked_n;
   logic              match;

   assign boundary_o = (cnt_q == CNT_W'(WORD_SLOTS - 1));
   assign match      = (clk_slots_i == CLK_SLOT_PATTERN);

   always_comb begin
      cnt_n    = (cnt_q == CNT_W'(WORD_SLOTS)) ? '0 :
                 (boundary_o ? '0 : cnt_q + 1'b1);
      good_n   = good_q;
      bad_n    = bad_q;
      locked_n = locked_q;
      if (boundary_o) begin
         if (!locked_q) begin
            if (match) begin
               if (good_q == GOOD_W'(LOCK_WORDS - 1)) begin
                  locked_n = 1'b1;
                  good_n   = '0;
               end else begin
                  good_n = good_q + 1'b1;
               end
            end else begin
               good_n = '0;
               cnt_n  = CNT_W'(WORD_SLOTS);   // one extra bit period: slip
            end
         end else if (match) begin
            bad_n = '0;
         end else if (bad_q == BAD_W'(DROP_WORDS - 1)) begin
            locked_n = 1'b0;
            bad_n    = '0;
         end else begin
            bad_n = bad_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         good_q   <= '0;
         bad_q    <= '0;
         locked_q <= 1'b0;
      end else begin
         cnt_q    <= cnt_n;
         good_q   <= good_n;
         bad_q    <= bad_n;
         locked_q <= locked_n;
      end
   end

   assign lock_next_o = locked_n;
   assign locked_o    = locked_q;

   // R2: a miss while hunting delays the next boundary by one bit
   p_slip_on_miss_r2: assert property (@(posedge clk) disable iff (rst)
      (boundary_o && !locked_q && !match) |=> (cnt_q == CNT_W'(WORD_SLOTS)));

   // R3: lock only rises at a matching boundary
   p_lock_from_match_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(locked_q) |-> $past(boundary_o && match));

   // R4: lock only falls at a mismatching boundary
   p_drop_from_miss_r4: assert property (@(posedge clk) disable iff (rst)
      $fell(locked_q) |-> $past(boundary_o && !match));

   // R4: a matching word never loses lock
   p_hold_on_match_r4: assert property (@(posedge clk) disable iff (rst)
      (locked_q && boundary_o && match) |=> locked_q);

endmodule

// File: rtl/lvds_pixel_unpack.sv
module lvds_pixel_unpack
   import lvds_rx_pkg::*;
#(
   parameter int DATA_LANES = 4
)(
   input  logic [DATA_LANES-1:0][WORD_SLOTS-1:0] slots_i,
   input  logic [1:0]                            map_mode_i,
   output logic [7:0]                            red_o,
   output logic [7:0]                            green_o,
   output logic [7:0]                            blue_o,
   output logic                                  hsync_o,
   output logic                                  vsync_o,
   output logic                                  de_o
);

   logic [WORD_SLOTS-1:0] l0, l1, l2;
   logic [5:0] r6, g6, b6;
   logic [1:0] r2, g2, b2;
   logic       has_l3;
   map_mode_e  mode;

   assign l0 = slots_i[0];
   assign l1 = slots_i[1];
   assign l2 = slots_i[2];

   assign r6 = {l0[1], l0[2], l0[3], l0[4], l0[5], l0[6]};
   assign g6 = {l1[2], l1[3], l1[4], l1[5], l1[6], l0[0]};
   assign b6 = {l2[3], l2[4], l2[5], l2[6], l1[0], l1[1]};

   assign de_o    = l2[0];
   assign vsync_o = l2[1];
   assign hsync_o = l2[2];

   if (DATA_LANES == 4) begin : g_four
      logic [WORD_SLOTS-1:0] l3;
      logic                  unused_ctl3;
      assign l3          = slots_i[3];
      assign unused_ctl3 = l3[0];
      assign b2     = {l3[1], l3[2]};
      assign g2     = {l3[3], l3[4]};
      assign r2     = {l3[5], l3[6]};
      assign has_l3 = 1'b1;
   end else begin : g_three
      assign r2     = '0;
      assign g2     = '0;
      assign b2     = '0;
      assign has_l3 = 1'b0;
   end

   assign mode = map_mode_e'(map_mode_i);

   always_comb begin
      red_o   = {r6, r6[5:4]};
      green_o = {g6, g6[5:4]};
      blue_o  = {b6, b6[5:4]};
      if (has_l3) begin
         unique case (mode)
            MAP_WIDE_LOLN3: begin
               red_o   = {r6, r2};
               green_o = {g6, g2};
               blue_o  = {b6, b2};
            end
            MAP_WIDE_HILN3: begin
               red_o   = {r2, r6};
               green_o = {g2, g6};
               blue_o  = {b2, b6};
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/lvds_rx_align.sv
module lvds_rx_align
   import lvds_rx_pkg::*;
#(
   parameter int DATA_LANES = 4,
   parameter int LOCK_WORDS = 4,
   parameter int DROP_WORDS = 2
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  mirror_i,
   input  logic [1:0]            map_mode_i,
   input  logic                  clk_lane_i,
   input  logic [DATA_LANES-1:0] data_lane_i,
   output logic [7:0]            red_o,
   output logic [7:0]            green_o,
   output logic [7:0]            blue_o,
   output logic                  hsync_o,
   output logic                  vsync_o,
   output logic                  de_o,
   output logic                  pix_valid_o,
   output logic                  locked_o
);

   if (DATA_LANES != 3 && DATA_LANES != 4) begin : g_bad_lanes
      $error("DATA_LANES must be 3 or 4");
   end
   if (WORD_SLOTS != 7) begin : g_bad_slots
      $error("word length must be 7 slots");
   end

   logic [WORD_SLOTS-1:0]                 clk_slots;
   logic [DATA_LANES-1:0][WORD_SLOTS-1:0] data_slots;
   logic                                  boundary, lock_next;
   logic [7:0] r_d, g_d, b_d;
   logic       hs_d, vs_d, de_d;

   lvds_slot_deser u_clk_deser (
      .clk      (clk),
      .rst      (rst),
      .bit_i    (clk_lane_i),
      .mirror_i (mirror_i),
      .slots_o  (clk_slots)
   );

   for (genvar ln = 0; ln < DATA_LANES; ln++) begin : g_lane
      lvds_slot_deser u_deser (
         .clk      (clk),
         .rst      (rst),
         .bit_i    (data_lane_i[ln]),
         .mirror_i (mirror_i),
         .slots_o  (data_slots[ln])
      );
   end

   lvds_word_align #(
      .LOCK_WORDS (LOCK_WORDS),
      .DROP_WORDS (DROP_WORDS)
   ) u_align (
      .clk         (clk),
      .rst         (rst),
      .clk_slots_i (clk_slots),
      .boundary_o  (boundary),
      .lock_next_o (lock_next),
      .locked_o    (locked_o)
   );

   lvds_pixel_unpack #(.DATA_LANES(DATA_LANES)) u_unpack (
      .slots_i    (data_slots),
      .map_mode_i (map_mode_i),
      .red_o      (r_d),
      .green_o    (g_d),
      .blue_o     (b_d),
      .hsync_o    (hs_d),
      .vsync_o    (vs_d),
      .de_o       (de_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         red_o       <= '0;
         green_o     <= '0;
         blue_o      <= '0;
         hsync_o     <= 1'b0;
         vsync_o     <= 1'b0;
         de_o        <= 1'b0;
         pix_valid_o <= 1'b0;
      end else if (boundary && lock_next) begin
         red_o       <= r_d;
         green_o     <= g_d;
         blue_o      <= b_d;
         hsync_o     <= hs_d;
         vsync_o     <= vs_d;
         de_o        <= de_d;
         pix_valid_o <= 1'b1;
      end else begin
         pix_valid_o <= 1'b0;
      end
   end

   // R1: reset leaves every output low
   p_reset_clears_r1: assert property (@(posedge clk)
      rst |=> (!locked_o && !pix_valid_o && red_o == 8'd0 && green_o == 8'd0
               && blue_o == 8'd0 && !hsync_o && !vsync_o && !de_o));

   // R5: strobe only while locked
   p_valid_locked_r5: assert property (@(posedge clk) disable iff (rst)
      pix_valid_o |-> locked_o);

   // R5: strobe lasts one cycle
   p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
      pix_valid_o |=> !pix_valid_o);

endmodule

// File: tb/lvds_rx_align_tb.sv
`timescale 1ns/1ps
module lvds_rx_align_tb;

   localparam logic [6:0] PAT = 7'b1100011;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       mirror = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       clk_lane = 1'b0;
   logic [3:0] data_lane = 4'd0;
   logic [7:0] red, green, blue;
   logic       hs, vs, de, pv, locked;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   lvds_rx_align u_dut (
      .clk(clk), .rst(rst), .mirror_i(mirror), .map_mode_i(mode),
      .clk_lane_i(clk_lane), .data_lane_i(data_lane),
      .red_o(red), .green_o(green), .blue_o(blue),
      .hsync_o(hs), .vsync_o(vs), .de_o(de),
      .pix_valid_o(pv), .locked_o(locked)
   );

   task automatic chk(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic lane_bit(input int lane, input int slot, input int md,
                                     input logic [7:0] r, g, b,
                                     input logic h, v, e);
      logic [5:0] r6, g6, b6;
      logic [1:0] r2, g2, b2;
      if (md == 2) begin
         r6 = r[5:0]; g6 = g[5:0]; b6 = b[5:0];
         r2 = r[7:6]; g2 = g[7:6]; b2 = b[7:6];
      end else begin
         r6 = r[7:2]; g6 = g[7:2]; b6 = b[7:2];
         r2 = r[1:0]; g2 = g[1:0]; b2 = b[1:0];
      end
      case (lane)
         0: return (slot == 0) ? g6[0] : r6[6-slot];
         1: return (slot == 0) ? b6[1] : (slot == 1) ? b6[0] : g6[7-slot];
         2: return (slot == 0) ? e : (slot == 1) ? v : (slot == 2) ? h : b6[8-slot];
         default: begin
            if (md == 0 || md == 3) return 1'b1;   // junk on an unused lane
            case (slot)
               0: return 1'b0;
               1: return b2[1];
               2: return b2[0];
               3: return g2[1];
               4: return g2[0];
               5: return r2[1];
               default: return r2[0];
            endcase
         end
      endcase
   endfunction

   function automatic logic [7:0] exp_col(input int md, input logic [7:0] c);
      if (md == 1 || md == 2) return c;
      return {c[7:2], c[7:6]};
   endfunction

   // sends one word; returns 1 ns after the edge that samples its last slot
   task automatic send_word(input logic [7:0] r, g, b, input logic h, v, e,
                            input logic clk_ok);
      for (int t = 0; t < 7; t++) begin
         int slot;
         slot = mirror ? 6 - t : t;
         @(negedge clk);
         if (t == 3 && locked) chk(pv, 0, "R5 strobe low mid-word");
         clk_lane = clk_ok ? PAT[slot] : 1'b0;
         for (int ln = 0; ln < 4; ln++)
            data_lane[ln] = lane_bit(ln, slot, int'(mode), r, g, b, h, v, e);
      end
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      clk_lane = 1'b0;
      data_lane = 4'd0;
      repeat (3) @(posedge clk);
      #1;
      chk(locked, 0, "R1 lock after reset");
      chk(pv, 0, "R1 strobe after reset");
      chk({red, green, blue}, 0, "R1 colours after reset");
      chk({hs, vs, de}, 0, "R1 controls after reset");
      rst = 1'b0;
   endtask

   task automatic lock_exact();
      for (int w = 1; w <= 4; w++) begin
         send_word(8'h11, 8'h22, 8'h33, 1'b0, 1'b0, 1'b0, 1'b1);
         chk(locked, (w == 4) ? 1 : 0, "R3 lock at fourth matching word");
         chk(pv, (w == 4) ? 1 : 0, "R5 strobe with lock");
      end
   endtask

   task automatic data_run(input int n, input int seed);
      string tag;
      case (mode)
         2'd0: tag = "R6";
         2'd1: tag = "R8";
         2'd2: tag = "R7";
         default: tag = "R11";
      endcase
      if (mirror) tag = {tag, " R10"};
      for (int i = 0; i < n; i++) begin
         logic [7:0] r, g, b;
         logic [2:0] c;
         r = 8'((i * 53 + seed * 17) & 255);
         g = 8'((i * 91 + seed * 7 + 40) & 255);
         b = 8'((i * 29 + seed * 3 + 200) & 255);
         c = 3'(i);
         send_word(r, g, b, c[0], c[1], c[2], 1'b1);
         chk(pv, 1, "R5 strobe per word");
         chk(red,   exp_col(int'(mode), r), {tag, " red"});
         chk(green, exp_col(int'(mode), g), {tag, " green"});
         chk(blue,  exp_col(int'(mode), b), {tag, " blue"});
         chk({hs, vs, de}, {c[0], c[1], c[2]}, "R9 controls");
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // every map mode, both slot orders
      for (int m = 0; m < 4; m++) begin
         for (int mr = 0; mr < 2; mr++) begin
            mode = 2'(m);
            mirror = mr[0];
            do_reset();
            lock_exact();
            data_run(24, m * 2 + mr);
         end
      end

      // drop and relock
      mode = 2'd2;
      mirror = 1'b0;
      do_reset();
      lock_exact();
      send_word(8'h5A, 8'hA5, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b0);
      chk(locked, 1, "R4 single miss keeps lock");
      chk(pv, 1, "R4 strobe on single miss");
      send_word(8'h01, 8'h02, 8'h03, 1'b0, 1'b0, 1'b1, 1'b1);
      chk(locked, 1, "R4 match after miss");
      send_word(8'h01, 8'h02, 8'h03, 1'b0, 1'b0, 1'b1, 1'b0);
      chk(locked, 1, "R4 miss count cleared by match");
      send_word(8'h01, 8'h02, 8'h03, 1'b0, 1'b0, 1'b1, 1'b0);
      chk(locked, 0, "R4 second miss drops lock");
      chk(pv, 0, "R4 no strobe after drop");
      for (int w = 1; w <= 4; w++) begin
         send_word(8'h44, 8'h55, 8'h66, 1'b0, 1'b0, 1'b1, 1'b1);
         chk(locked, (w == 4) ? 1 : 0, "R4 relock at fourth word");
      end
      data_run(4, 9);

      // every starting offset
      for (int sk = 0; sk < 7; sk++) begin
         int words;
         mode = 2'd1;
         mirror = sk[0];
         do_reset();
         for (int s = 0; s < sk; s++) begin
            @(negedge clk);
            clk_lane = 1'b0;
            data_lane = 4'd0;
         end
         words = 0;
         while (!locked && words < 16) begin
            send_word(8'h77, 8'h88, 8'h99, 1'b0, 1'b1, 1'b0, 1'b1);
            words++;
            if (!locked) chk(pv, 0, "R5 no strobe while hunting");
         end
         chk(locked, 1, "R2 lock from offset");
         chk(words >= 4 ? 1 : 0, 1, "R3 at least four words to lock");
         data_run(3, 20 + sk);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule